// File: doc/BRIEF.md
# In-Order Response Latency Window Checker

This block is a synthesizable monitor. It watches a request line and a response line that share one clock. Every rising edge on the request line opens a checking attempt. That attempt must be answered by a later rising edge on the response line, and the answer must arrive within a bounded number of cycles after the attempt opened. The monitor reports each verdict as a one-cycle pass or fail pulse. It also keeps a sticky flag that records whether any request had to be dropped because too many attempts were already pending.

Attempts are served strictly in the order they were opened. Each attempt receives a sequence tag when it starts. A separate serviced-tag counter selects which attempt may look at the response line. Only the oldest pending attempt can take a response, and each response edge is used by at most one attempt. This stops two overlapping requests from both being satisfied by the same response. The start times of pending attempts are held in a small FIFO. The window bounds and the FIFO depth are parameters.

Top module: `latency_window_monitor`

## Requirements
- R1: An attempt opens only in a cycle where `reqIn` is 1 and was 0 in the previous cycle. Holding `reqIn` high for several cycles opens exactly one attempt.
- R2: Let the attempt open at sampling edge T and the response rise at edge U. If U−T is between MIN_LAT and MAX_LAT inclusive (defaults 5 and 10), the attempt passes. `passPulse` is then 1 for exactly the one cycle after edge U.
- R3: If the response rises when the active attempt's age U−T is below MIN_LAT, the attempt fails. `failPulse` is 1 for the one cycle after edge U.
- R4: If no response rises before the active attempt's age reaches MAX_LAT+1, the attempt fails. `failPulse` is 1 in the cycle after the edge at which the age equals MAX_LAT+1.
- R5: Responses are matched in order. With requests rising at cycles 2 and 4 and responses rising at 8 and 10, the first attempt passes at 8 and the second passes at 10.
- R6: A resolved attempt releases the next pending attempt, whether it passed or failed. The response edge that resolved it is not offered to the next attempt, even when it would fall inside that attempt's window.
- R7: A response rising edge while no attempt is pending produces neither a pass nor a fail.
- R8: A request rising edge sampled while DEPTH attempts are pending is not tracked. It sets `overflowFlag`, which stays 1 until reset. The flag shows in the cycle after that edge.
- R9: A synchronous active-high `rst` clears all pending attempts, both tag counters and all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqIn | input | 1 | Monitored request line; its rising edge opens an attempt |
| rspIn | input | 1 | Monitored response line; its rising edge answers the oldest attempt |
| passPulse | output | 1 | One-cycle pulse when the active attempt is answered inside the window |
| failPulse | output | 1 | One-cycle pulse when the active attempt is answered too early or times out |
| overflowFlag | output | 1 | Sticky flag set when a request arrives with the FIFO full |

## Verification
The bench targets the overlap cases. In one, a single response falls inside the windows of two pending requests. A design that let any open attempt take that response would report two passes where the second attempt should time out. In another, an early response fails the first attempt and a later one passes the second. A design that re-offered the consuming edge to the next attempt would pass the wrong attempt or misplace the pulse. The exact window ends (ages 5 and 10), the age-11 timeout, a held request level, orphan responses and a fifth request into a four-deep FIFO are also checked. A design that is off by one on a bound, that retriggers on a level, or that tracks the dropped request would each emit a pulse in a cycle where none is expected, or miss one.

// File: rtl/lwm_pkg.sv
package lwm_pkg;

  // Strobes from control to datapath, valid for one sampling edge
  typedef struct packed {
    logic push;   // record a new attempt
    logic pop;    // retire the active attempt
    logic pass;   // active attempt answered inside the window
    logic fail;   // active attempt answered early or timed out
    logic ovf;    // request dropped, FIFO full
  } lwmStrobes_t;

endpackage

// File: rtl/lwm_control.sv
module lwm_control
  import lwm_pkg::*;
#(
  parameter int MIN_LAT = 5,
  parameter int MAX_LAT = 10,
  parameter int TS_W    = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reqIn,
  input  logic            rspIn,
  input  logic            empty,
  input  logic            full,
  input  logic [TS_W-1:0] headAge,
  output lwmStrobes_t     strb
);

  logic reqPrev, rspPrev;
  logic reqRise, rspRise;
  logic active, inWindow, expired;

  always_ff @(posedge clk) begin
    if (rst) begin
      reqPrev <= 1'b0;
      rspPrev <= 1'b0;
    end else begin
      reqPrev <= reqIn;
      rspPrev <= rspIn;
    end
  end

  assign reqRise  = reqIn & ~reqPrev;
  assign rspRise  = rspIn & ~rspPrev;
  assign active   = ~empty;
  assign inWindow = (headAge >= TS_W'(MIN_LAT)) && (headAge <= TS_W'(MAX_LAT));
  assign expired  = headAge > TS_W'(MAX_LAT);

  always_comb begin
    strb      = '0;
    // only the oldest attempt may see the response; one edge, one attempt
    strb.pass = active & rspRise & inWindow;
    strb.fail = active & ~inWindow & (rspRise | expired);
    strb.pop  = strb.pass | strb.fail;
    strb.push = reqRise & ~full;
    strb.ovf  = reqRise & full;
  end

  // R6
  one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    !(strb.pass && strb.fail));

endmodule

// File: rtl/lwm_datapath.sv
module lwm_datapath
  import lwm_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int MAX_LAT = 10,
  parameter int TS_W    = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  lwmStrobes_t     strb,
  output logic            empty,
  output logic            full,
  output logic [TS_W-1:0] headAge,
  output logic            passPulse,
  output logic            failPulse,
  output logic            overflowFlag
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int TAG_W = $clog2(DEPTH) + 2;  // wraps at >= 2*DEPTH

  logic [TS_W-1:0]  cycleCnt;
  logic [TS_W-1:0]  tsMem  [DEPTH];
  logic [TAG_W-1:0] tagMem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [TAG_W-1:0] issueTag, servedTag;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) cycleCnt <= '0;
    else     cycleCnt <= cycleCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        tsMem[i]  <= '0;
        tagMem[i] <= '0;
      end
    end else if (strb.push) begin
      tsMem[wrPtr]  <= cycleCnt;
      tagMem[wrPtr] <= issueTag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      issueTag  <= '0;
      servedTag <= '0;
    end else begin
      if (strb.push) begin
        wrPtr    <= advance(wrPtr);
        issueTag <= issueTag + 1'b1;
      end
      if (strb.pop) begin
        rdPtr     <= advance(rdPtr);
        servedTag <= servedTag + 1'b1;
      end
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      passPulse    <= 1'b0;
      failPulse    <= 1'b0;
      overflowFlag <= 1'b0;
    end else begin
      passPulse    <= strb.pass;
      failPulse    <= strb.fail;
      overflowFlag <= overflowFlag | strb.ovf;
    end
  end

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign headAge = cycleCnt - tsMem[rdPtr];

  // R5
  head_tag_chk: assert property (@(posedge clk) disable iff (rst)
    !empty |-> tagMem[rdPtr] == servedTag);

  // R5
  count_tag_chk: assert property (@(posedge clk) disable iff (rst)
    TAG_W'(count) == TAG_W'(issueTag - servedTag));

  // R4
  age_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !empty |-> headAge <= TS_W'(MAX_LAT + 1));

  // R7
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> !strb.pop);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflowFlag |=> overflowFlag);

endmodule

// File: rtl/latency_window_monitor.sv
module latency_window_monitor
  import lwm_pkg::*;
#(
  parameter int MIN_LAT = 5,
  parameter int MAX_LAT = 10,
  parameter int DEPTH   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic reqIn,
  input  logic rspIn,
  output logic passPulse,
  output logic failPulse,
  output logic overflowFlag
);

  // ages never exceed MAX_LAT+1 while an attempt is at the head
  localparam int TS_W = $clog2(MAX_LAT + 2) + 1;

  lwmStrobes_t     strb;
  logic            empty, full;
  logic [TS_W-1:0] headAge;

  lwm_control #(
    .MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT), .TS_W(TS_W)
  ) u_control (
    .clk(clk), .rst(rst), .reqIn(reqIn), .rspIn(rspIn),
    .empty(empty), .full(full), .headAge(headAge), .strb(strb)
  );

  lwm_datapath #(
    .DEPTH(DEPTH), .MAX_LAT(MAX_LAT), .TS_W(TS_W)
  ) u_datapath (
    .clk(clk), .rst(rst), .strb(strb),
    .empty(empty), .full(full), .headAge(headAge),
    .passPulse(passPulse), .failPulse(failPulse), .overflowFlag(overflowFlag)
  );

endmodule

// File: tb/latency_window_monitor_bench.sv
module latency_window_monitor_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqIn = 1'b0;
  logic rspIn = 1'b0;
  logic passPulse, failPulse, overflowFlag;

  latency_window_monitor u_latency_window_monitor (
    .clk(clk), .rst(rst), .reqIn(reqIn), .rspIn(rspIn),
    .passPulse(passPulse), .failPulse(failPulse), .overflowFlag(overflowFlag)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    edgeCnt = 0;
  int    nRun = 0;
  int    nFail = 0;
  bit    monOn = 1'b0;
  bit    done = 1'b0;
  int    ovfCyc = 32'h7fffffff;
  string curTag = "";
  int    expCyc[$];
  int    expKind[$];  // 1 = pass, 2 = fail

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s at edge %0d: actual %0d expected %0d", tag, what, edgeCnt, act, exp);
    end
  endtask

  // monitor: outputs registered at edge n are compared at the following negedge
  always @(negedge clk) begin
    int ePass;
    int eFail;
    int eOvf;
    if (monOn) begin
      ePass = 0;
      eFail = 0;
      if (expCyc.size() > 0 && expCyc[0] == edgeCnt) begin
        if (expKind[0] == 1) ePass = 1;
        else                 eFail = 1;
        void'(expCyc.pop_front());
        void'(expKind.pop_front());
      end
      eOvf = (edgeCnt >= ovfCyc) ? 1 : 0;
      check(passPulse == ePass[0], curTag, "passPulse", int'(passPulse), ePass);
      check(failPulse == eFail[0], curTag, "failPulse", int'(failPulse), eFail);
      check(overflowFlag == eOvf[0], curTag, "overflowFlag", int'(overflowFlag), eOvf);
    end
  end

  function automatic logic [63:0] b(int i);
    return 64'd1 << i;
  endfunction

  // driver: level patterns per cycle offset; expected verdict edges pushed to the scoreboard
  task automatic runCase(string tag, logic [63:0] reqP, logic [63:0] rspP,
                         logic [63:0] passP, logic [63:0] failP, int ovfOff, int len);
    int base;
    @(negedge clk);
    base   = edgeCnt + 1;
    curTag = tag;
    for (int c = 0; c < len; c++) begin
      if (passP[c]) begin expCyc.push_back(base + c); expKind.push_back(1); end
      if (failP[c]) begin expCyc.push_back(base + c); expKind.push_back(2); end
    end
    if (ovfOff >= 0) ovfCyc = base + ovfOff;
    for (int c = 0; c < len; c++) begin
      reqIn = reqP[c];
      rspIn = rspP[c];
      @(negedge clk);
    end
    reqIn = 1'b0;
    rspIn = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(!passPulse && !failPulse && !overflowFlag, "R9", "reset outputs",
          {29'd0, passPulse, failPulse, overflowFlag}, 0);
    monOn = 1'b1;

    // R5: overlapping requests at 2,4 with responses at 8,10
    runCase("R5", b(2) | b(4), b(8) | b(10), b(8) | b(10), 64'd0, -1, 24);
    // R2: lower bound (age 5) then upper bound (age 10)
    runCase("R2", b(1) | b(20), b(6) | b(30), b(6) | b(30), 64'd0, -1, 40);
    // R1: request held high 1..8 opens one attempt; no later timeout
    runCase("R1", (b(9) - 64'd1) & ~b(0), b(7), b(7), 64'd0, -1, 24);
    // R4: no response, fail when age reaches 11
    runCase("R4", b(1), 64'd0, 64'd0, b(12), -1, 16);
    // R3: response at age 4 fails early
    runCase("R3", b(1), b(5), 64'd0, b(5), -1, 20);
    // R7: orphan response
    runCase("R7", 64'd0, b(3), 64'd0, 64'd0, -1, 10);
    // R6: one response in both windows serves only the first; second times out
    runCase("R6", b(1) | b(3), b(9), b(9), b(14), -1, 20);
    // R6: early fail releases next; consuming edge not reused
    runCase("R6", b(1) | b(3), b(4) | b(10), b(10), b(4), -1, 20);
    // R8: fifth request into four-deep FIFO is dropped, flag sticks
    runCase("R8", b(1) | b(3) | b(5) | b(7) | b(9), 64'd0, 64'd0,
            b(12) | b(14) | b(16) | b(18), 9, 30);

    check(expCyc.size() == 0, "R5", "leftover expected verdicts", expCyc.size(), 0);

    // R9: reset clears the sticky flag
    @(negedge clk);
    monOn  = 1'b0;
    rst    = 1'b1;
    ovfCyc = 32'h7fffffff;
    @(negedge clk);
    rst = 1'b0;
    check(overflowFlag == 1'b0, "R9", "overflowFlag after reset", int'(overflowFlag), 0);
    check(!passPulse && !failPulse, "R9", "pulses after reset",
          int'(passPulse) + int'(failPulse), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL all watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule